// File: doc/BRIEF.md
# Trim Shadow Register Refresh Controller

This block keeps a set of live trim registers in step with the coefficient words held in a nonvolatile store. The live set is one configuration register and four 12-bit coefficient registers: offset, offset temperature coefficient, span, and span temperature coefficient. Analog trim logic reads these registers directly. The controller decides when a reload happens and then fetches the five words one at a time through the store's word port.

A reload can be requested in three ways. One request is pending at reset, so the registers are loaded after power-up. A rising edge of chip-select requests a reload unless the update-inhibit bit is set. A periodic timer also requests reloads, about 400 per second with the default period. The timer runs only while write-enable is high and no serial session is active, and it restarts from zero whenever it is stopped.

A load does not start while the store reports busy; it begins on the first cycle the store is idle. A request that arrives while a load is already running is absorbed into that load and is not queued. All control inputs are synchronous to the block clock.

Top module: `trim_shadow_refresh`

## Requirements
- R1: While reset is asserted, all five output registers read zero. After reset is released, one load starts without any other stimulus.
- R2: A load reads store addresses 0, 1, 2, 3 and 4 on consecutive cycles with `store_rd_o` high, and never reads an address above 4. Word 0 goes to `cfg_o`, word 1 to `ofs_o`, word 2 to `ofs_tc_o`, word 3 to `span_o` and word 4 to `span_tc_o`. Each register takes bits 11:0 of its word. The store returns the word on `store_data_i` in the cycle after the read.
- R3: A low-to-high change of `chip_sel_i` while `upd_inhibit_i` is 0 causes one full load.
- R4: A low-to-high change of `chip_sel_i` while `upd_inhibit_i` is 1 causes no load, and all registers keep their values.
- R5: While `wr_en_i` is 1 and `sess_active_i` is 0, a load is requested every `REFRESH_CYCLES` clock cycles.
- R6: While `wr_en_i` is 0, no periodic load occurs.
- R7: While `sess_active_i` is 1, no periodic load occurs.
- R8: No load starts while `store_busy_i` is 1. A pending load starts on the first cycle that `store_busy_i` is 0.
- R9: A request raised while a load is in progress is merged into that load. It produces no second load.
- R10: The output registers change only two cycles after a store read, when the returned word is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_i | input | 1 | Chip-select level; a rising edge requests a reload |
| wr_en_i | input | 1 | Write-enable level; when high, enables the periodic refresh |
| upd_inhibit_i | input | 1 | Latched no-update bit; when high, blocks reloads on chip-select edges |
| sess_active_i | input | 1 | High while a serial session is active; blocks the periodic refresh |
| store_busy_i | input | 1 | Store busy; delays the start of a load |
| store_rd_o | output | 1 | Word read strobe to the store |
| store_addr_o | output | 3 | Word address, 0 to 4 |
| store_data_i | input | 16 | Read word, valid the cycle after the strobe |
| cfg_o | output | 12 | Configuration register |
| ofs_o | output | 12 | Offset coefficient |
| ofs_tc_o | output | 12 | Offset temperature coefficient |
| span_o | output | 12 | Span coefficient |
| span_tc_o | output | 12 | Span temperature coefficient |

## Verification
Every stored word has its upper four bits set. A design that copied the wrong slice, or sent a word to the wrong register, therefore shows a mismatch on every register. The bench changes the store contents before each trigger and then compares the registers, so a missed load or a load that should not happen cannot hide behind unchanged data. This covers an inhibited chip-select edge, a load while write-enable is low, and a load during an active session. A second chip-select edge is sent in the middle of a load; a controller that queued it instead of merging it would read the store twice. The store is held busy while a request is pending; a controller that ignored busy would read early, and one that lost the request would never read.

// File: rtl/trim_refresh_pkg.sv
package trim_refresh_pkg;
  localparam int NUM_REGS = 5;
  localparam int WORD_W   = 16;
  localparam int COEF_W   = 12;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int CNT_W    = $clog2(NUM_REGS + 1);

  typedef enum logic {
    SEQ_IDLE,
    SEQ_RUN
  } seq_state_e;
endpackage

// File: rtl/refresh_trigger.sv
module refresh_trigger #(
  parameter int REFRESH_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel_i,
  input  logic wr_en_i,
  input  logic upd_inhibit_i,
  input  logic sess_active_i,
  input  logic load_active_i,
  input  logic load_start_i,
  output logic pend_o
);
  localparam int TW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [TW-1:0] TMR_LAST = TW'(REFRESH_CYCLES - 1);

  logic          cs_q;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;
  logic          tmr_en, tick, cs_req, any_req;

  always_comb begin
    tmr_en  = wr_en_i && !sess_active_i;
    tick    = tmr_en && (tmr_q == TMR_LAST);
    cs_req  = chip_sel_i && !cs_q && !upd_inhibit_i;
    any_req = cs_req || tick;

    if (!tmr_en || tick) tmr_d = '0;
    else                 tmr_d = tmr_q + TW'(1);

    // a request during an active load is absorbed into it
    if (load_start_i)                    pend_d = 1'b0;
    else if (any_req && !load_active_i)  pend_d = 1'b1;
    else                                 pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      tmr_q  <= '0;
      pend_q <= 1'b1;   // power-up load
    end else begin
      cs_q   <= chip_sel_i;
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/load_sequencer.sv
module load_sequencer
  import trim_refresh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              active_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cap_vld_o,
  output logic [ADDR_W-1:0] cap_idx_o
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NUM_REGS);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_vld_q;
  logic [ADDR_W-1:0] cap_idx_q;

  always_comb begin
    start_o = (state_q == SEQ_IDLE) && pend_i && !busy_i;
    rd_o    = (state_q == SEQ_RUN) && (cnt_q < CNT_END);
    addr_o  = cnt_q[ADDR_W-1:0];
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: if (start_o) begin
        state_d = SEQ_RUN;
        cnt_d   = '0;
      end
      SEQ_RUN: begin
        if (cnt_q == CNT_END) state_d = SEQ_IDLE;
        else                  cnt_d   = cnt_q + CNT_W'(1);
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      cnt_q     <= '0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      cap_vld_q <= rd_o;
      cap_idx_q <= addr_o;
    end
  end

  assign active_o  = (state_q == SEQ_RUN);
  assign cap_vld_o = cap_vld_q;
  assign cap_idx_o = cap_idx_q;
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import trim_refresh_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cap_vld_i,
  input  logic [ADDR_W-1:0]                 cap_idx_i,
  input  logic [WORD_W-1:0]                 word_i,
  output logic [NUM_REGS-1:0][COEF_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              en;
    logic [COEF_W-1:0] val_q;
    assign en = cap_vld_i && (cap_idx_i == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (en) val_q <= word_i[COEF_W-1:0];
    end
    assign regs_o[g] = val_q;
  end
endmodule

// File: rtl/trim_shadow_refresh.sv
module trim_shadow_refresh
  import trim_refresh_pkg::*;
#(
  parameter int REFRESH_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_i,
  input  logic              wr_en_i,
  input  logic              upd_inhibit_i,
  input  logic              sess_active_i,
  input  logic              store_busy_i,
  output logic              store_rd_o,
  output logic [ADDR_W-1:0] store_addr_o,
  input  logic [WORD_W-1:0] store_data_i,
  output logic [COEF_W-1:0] cfg_o,
  output logic [COEF_W-1:0] ofs_o,
  output logic [COEF_W-1:0] ofs_tc_o,
  output logic [COEF_W-1:0] span_o,
  output logic [COEF_W-1:0] span_tc_o
);
  logic                            pend, start, active, cap_vld;
  logic [ADDR_W-1:0]               cap_idx;
  logic [NUM_REGS-1:0][COEF_W-1:0] regs;

  refresh_trigger #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_trig (
    .clk(clk), .rst_n(rst_n), .chip_sel_i(chip_sel_i), .wr_en_i(wr_en_i),
    .upd_inhibit_i(upd_inhibit_i), .sess_active_i(sess_active_i),
    .load_active_i(active), .load_start_i(start), .pend_o(pend)
  );

  load_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .busy_i(store_busy_i),
    .start_o(start), .active_o(active), .rd_o(store_rd_o),
    .addr_o(store_addr_o), .cap_vld_o(cap_vld), .cap_idx_o(cap_idx)
  );

  shadow_bank u_bank (
    .clk(clk), .rst_n(rst_n), .cap_vld_i(cap_vld), .cap_idx_i(cap_idx),
    .word_i(store_data_i), .regs_o(regs)
  );

  assign cfg_o     = regs[0];
  assign ofs_o     = regs[1];
  assign ofs_tc_o  = regs[2];
  assign span_o    = regs[3];
  assign span_tc_o = regs[4];
endmodule

// File: rtl/trim_refresh_chk.sv
module trim_refresh_chk
  import trim_refresh_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              store_busy_i,
  input logic              store_rd_o,
  input logic [ADDR_W-1:0] store_addr_o,
  input logic [COEF_W-1:0] cfg_o,
  input logic [COEF_W-1:0] ofs_o,
  input logic [COEF_W-1:0] ofs_tc_o,
  input logic [COEF_W-1:0] span_o,
  input logic [COEF_W-1:0] span_tc_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [5*COEF_W-1:0] all_regs;
  assign all_regs = {cfg_o, ofs_o, ofs_tc_o, span_o, span_tc_o};

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_rd_o |-> (store_addr_o <= LAST_ADDR));

  // R2
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_rd_o) |-> (store_addr_o == '0));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_rd_o && store_addr_o != LAST_ADDR) |=>
      (store_rd_o && store_addr_o == $past(store_addr_o) + ADDR_W'(1)));

  // R8
  busy_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_rd_o) |-> !$past(store_busy_i));

  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(store_rd_o, 2) |-> $stable(all_regs));
endmodule

bind trim_shadow_refresh trim_refresh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .store_busy_i(store_busy_i),
  .store_rd_o(store_rd_o), .store_addr_o(store_addr_o),
  .cfg_o(cfg_o), .ofs_o(ofs_o), .ofs_tc_o(ofs_tc_o),
  .span_o(span_o), .span_tc_o(span_tc_o)
);

// File: tb/trim_shadow_refresh_bench.sv
module trim_shadow_refresh_bench;
  localparam int P = 64;

  logic clk, rst_n, cs, we, inh, sess, busy;
  logic        rd;
  logic [2:0]  addr;
  logic [15:0] rdata;
  logic [11:0] cfg, ofs, ofs_tc, span, span_tc;
  logic [15:0] mem [5];

  int checks = 0, fails = 0, loads = 0, cyc = 0;
  int alog [16];
  int alog_n = 0;
  logic log_clr = 1'b0;
  logic done = 1'b0;

  trim_shadow_refresh #(.REFRESH_CYCLES(P)) u_trim_shadow_refresh (
    .clk(clk), .rst_n(rst_n), .chip_sel_i(cs), .wr_en_i(we),
    .upd_inhibit_i(inh), .sess_active_i(sess), .store_busy_i(busy),
    .store_rd_o(rd), .store_addr_o(addr), .store_data_i(rdata),
    .cfg_o(cfg), .ofs_o(ofs), .ofs_tc_o(ofs_tc), .span_o(span),
    .span_tc_o(span_tc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // store model: word returned the cycle after the strobe
  always @(posedge clk) begin
    if (rd) rdata <= mem[addr];
    if (rd && addr == 3'd0) loads <= loads + 1;
    if (log_clr) alog_n <= 0;
    else if (rd && alog_n < 16) begin
      alog[alog_n] <= int'(addr);
      alog_n <= alog_n + 1;
    end
    cyc <= cyc + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(logic [11:0] base);
    for (int i = 0; i < 5; i++) mem[i] = 16'hF000 | 16'(base + 12'(i * 'h111));
  endtask

  task automatic check_regs(string req, logic [11:0] base);
    check(req, 32'(cfg),     32'(base));
    check(req, 32'(ofs),     32'(base + 12'h111));
    check(req, 32'(ofs_tc),  32'(base + 12'h222));
    check(req, 32'(span),    32'(base + 12'h333));
    check(req, 32'(span_tc), 32'(base + 12'h444));
  endtask

  task automatic pulse_cs();
    cs = 1'b1; wait_n(1); cs = 1'b0; wait_n(1);
  endtask

  task automatic t_reset();
    check("R1", 32'({cfg, ofs, ofs_tc, span, span_tc}), 32'(0));
    check("R1", 32'(span_tc), 32'(0));
    log_clr = 1'b1; wait_n(1); log_clr = 1'b0;
    rst_n = 1'b1;
    wait_n(12);
    check("R1", 32'(loads), 32'(1));
    check_regs("R1", 12'h010);
  endtask

  task automatic t_order();
    // R2: address sequence of the power-up load
    check("R2", 32'(alog_n), 32'(5));
    for (int i = 0; i < 5; i++) check("R2", 32'(alog[i]), 32'(i));
  endtask

  task automatic t_cs_load();
    int l0 = loads;
    fill(12'h020);
    pulse_cs(); wait_n(10);
    check("R3", 32'(loads - l0), 32'(1));
    check_regs("R3", 12'h020);
  endtask

  task automatic t_inhibit();
    int l0 = loads;
    inh = 1'b1; fill(12'h030);
    pulse_cs(); wait_n(10);
    check("R4", 32'(loads - l0), 32'(0));
    check_regs("R4", 12'h020);   // R10: no capture without a read
    inh = 1'b0;
  endtask

  task automatic t_periodic();
    int l0 = loads;
    fill(12'h040);
    we = 1'b1; wait_n(3 * P + P / 2); we = 1'b0; wait_n(8);
    check("R5", 32'(loads - l0), 32'(3));
    check_regs("R5", 12'h040);
  endtask

  task automatic t_we_low();
    int l0 = loads;
    fill(12'h050);
    wait_n(3 * P);
    check("R6", 32'(loads - l0), 32'(0));
    check_regs("R6", 12'h040);
  endtask

  task automatic t_session();
    int l0 = loads;
    sess = 1'b1; we = 1'b1; wait_n(3 * P);
    check("R7", 32'(loads - l0), 32'(0));
    check_regs("R7", 12'h040);
    we = 1'b0; sess = 1'b0; wait_n(2);
  endtask

  task automatic t_busy();
    int l0 = loads;
    fill(12'h060);
    busy = 1'b1; pulse_cs(); wait_n(10);
    check("R8", 32'(loads - l0), 32'(0));
    busy = 1'b0; wait_n(3);
    check("R8", 32'(loads - l0), 32'(1));
    wait_n(8);
    check_regs("R8", 12'h060);
  endtask

  task automatic t_merge();
    int l0 = loads;
    fill(12'h070);
    cs = 1'b1; wait_n(1); cs = 1'b0; wait_n(1);
    cs = 1'b1; wait_n(1); cs = 1'b0;   // second edge lands mid-load
    wait_n(15);
    check("R9", 32'(loads - l0), 32'(1));
    check_regs("R9", 12'h070);
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; inh = 1'b0; sess = 1'b0; busy = 1'b0;
    fill(12'h010);
    wait_n(3);
    t_reset();
    t_order();
    t_cs_load();
    t_inhibit();
    t_periodic();
    t_we_low();
    t_session();
    t_busy();
    t_merge();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (!done && cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule